// File: doc/BRIEF.md
# Gate Driver Output-Disable Controller

This block decides when the output stage of a gate driver must stop driving and go to high impedance. A disable request can come from two places. The first is an external disable pin, which is asynchronous, so the block synchronizes it first. The second is an error pulse from an output-stage monitor. A monitor error is held in a latch, and only a falling edge of the synchronized pin level clears that latch. The pin level itself forces high impedance for as long as it stays high.

The block drives four things:
- a high-impedance status flag;
- an enable for the turn-on and turn-off outputs, which is the inverse of that flag;
- a sticky error flag, which stays set until software clears it with a strobe;
- a one-cycle fault event, raised when the block enters high impedance.

Two configuration inputs shape the behaviour. One blocks the monitor from latching. The other suppresses the fault event when the pin alone caused the disable.

Top module: `gdrv_outdis`

## Requirements
- R1: After reset, `hiz` is 0, `drv_en` is 1, `sticky_err` is 0 and `evt_fault` is 0.
- R2: A high level on `pin_dis` reaches `hiz` two clock edges after it is sampled, which sets `hiz`=1 and `drv_en`=0. While the latch is clear, a low pin level returns the block to `hiz`=0 and `drv_en`=1.
- R3: When `mon_err`=1 and `cfg_mon_inhibit`=0 at a clock edge, the latch is set and `hiz` is 1 from the next cycle on. The latch holds after `mon_err` drops, even while the pin stays low.
- R4: When `cfg_mon_inhibit`=1, `mon_err` has no effect: `hiz` stays 0 and no event is produced.
- R5: A falling edge of the synchronized pin level clears the latch. If a set and a clear fall on the same edge, the set wins.
- R6: When the monitor causes `hiz` to rise, `evt_fault` pulses, whatever `cfg_evt_mask` holds.
- R7: When the pin alone causes `hiz` to rise, `evt_fault` pulses only if `cfg_evt_mask`=0. With `cfg_evt_mask`=1, no pulse is produced.
- R8: `sticky_err` becomes 1 at the edge after `hiz` is seen at 1, whatever `cfg_evt_mask` holds. It stays 1 until `sticky_clr` is pulsed while `hiz`=0. While `hiz`=1, a strobe on `sticky_clr` leaves it at 1.
- R9: `evt_fault` is 1 only in the first cycle of `hiz`=1. A disable that is held produces a single pulse, and a second request that arrives while `hiz` is already 1 produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_dis | input | 1 | External disable pin, asynchronous; high requests high impedance |
| mon_err | input | 1 | Error pulse from the output-stage monitor |
| cfg_mon_inhibit | input | 1 | 1 blocks the monitor from setting the latch |
| cfg_evt_mask | input | 1 | 1 suppresses the event for pin-only disables |
| sticky_clr | input | 1 | Clear strobe for the sticky error flag |
| hiz | output | 1 | High-impedance status: latch OR synchronized pin level |
| drv_en | output | 1 | Enable for the turn-on and turn-off outputs |
| sticky_err | output | 1 | Sticky output-stage error flag |
| evt_fault | output | 1 | One-cycle fault event |

## Verification
The sticky flag's set condition (`hiz` at 1) and the software clear strobe can fall in the same cycle. The bench holds the pin high until the block is in high impedance, then asserts `sticky_clr` for two cycles while `hiz` stays 1. It expects `sticky_err` to read 1 afterwards, and 0 only after a strobe issued once `hiz` is back at 0.

The latch's monitor set and pin-fall clear can also meet on one edge. A bound property covers that case by requiring `hiz` one cycle after any accepted monitor error.

// File: rtl/gdrv_outdis.sv
module gdrv_outdis #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_dis,
  input  logic mon_err,
  input  logic cfg_mon_inhibit,
  input  logic cfg_evt_mask,
  input  logic sticky_clr,
  output logic hiz,
  output logic drv_en,
  output logic sticky_err,
  output logic evt_fault
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic pin_lvl, pin_prev_q, pin_fall;
  logic ctl_q, hiz_prev_q, sticky_q;
  logic mon_set;

  assign pin_lvl  = sync_q[SYNC_STAGES-1];
  assign pin_fall = pin_prev_q & ~pin_lvl;
  assign mon_set  = mon_err & ~cfg_mon_inhibit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= '0;
      pin_prev_q <= 1'b0;
    end else begin
      sync_q     <= {sync_q[SYNC_STAGES-2:0], pin_dis};
      pin_prev_q <= pin_lvl;
    end
  end

  // monitor set dominates a same-edge pin-fall clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctl_q <= 1'b0;
    else if (mon_set)  ctl_q <= 1'b1;
    else if (pin_fall) ctl_q <= 1'b0;
  end

  assign hiz    = ctl_q | pin_lvl;
  assign drv_en = ~hiz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hiz_prev_q <= 1'b0;
      sticky_q   <= 1'b0;
    end else begin
      hiz_prev_q <= hiz;
      if (hiz)             sticky_q <= 1'b1;
      else if (sticky_clr) sticky_q <= 1'b0;
    end
  end

  assign sticky_err = sticky_q;
  // a rise with the latch set is monitor-caused and never masked
  assign evt_fault  = hiz & ~hiz_prev_q & (ctl_q | ~cfg_evt_mask);

endmodule

// File: rtl/gdrv_outdis_chk.sv
module gdrv_outdis_chk (
  input logic clk,
  input logic rst_n,
  input logic mon_err,
  input logic cfg_mon_inhibit,
  input logic cfg_evt_mask,
  input logic hiz,
  input logic drv_en,
  input logic sticky_err,
  input logic evt_fault,
  input logic ctl
);

  assert_mon_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_err && !cfg_mon_inhibit) |=> hiz);

  assert_evt_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fault |-> (hiz && !$past(hiz)));

  assert_evt_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_fault |=> !evt_fault);

  assert_pin_evt_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_fault && !ctl) |-> !cfg_evt_mask);

  assert_mon_evt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hiz && !$past(hiz) && ctl) |-> evt_fault);

  assert_sticky_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hiz |=> sticky_err);

  assert_drv_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl |-> !drv_en);

endmodule

bind gdrv_outdis gdrv_outdis_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mon_err(mon_err), .cfg_mon_inhibit(cfg_mon_inhibit),
  .cfg_evt_mask(cfg_evt_mask), .hiz(hiz), .drv_en(drv_en), .sticky_err(sticky_err),
  .evt_fault(evt_fault), .ctl(ctl_q)
);

// File: tb/tb_gdrv_outdis.sv
module tb_gdrv_outdis;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_dis = 1'b0, mon_err = 1'b0, cfg_mon_inhibit = 1'b0;
  logic cfg_evt_mask = 1'b0, sticky_clr = 1'b0;
  logic hiz, drv_en, sticky_err, evt_fault;
  int checks = 0, errors = 0, evt_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gdrv_outdis dut (
    .clk(clk), .rst_n(rst_n), .pin_dis(pin_dis), .mon_err(mon_err),
    .cfg_mon_inhibit(cfg_mon_inhibit), .cfg_evt_mask(cfg_evt_mask),
    .sticky_clr(sticky_clr), .hiz(hiz), .drv_en(drv_en),
    .sticky_err(sticky_err), .evt_fault(evt_fault)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (evt_fault) evt_cnt++;
    end
  endtask

  task automatic t_reset();
    step(1);
    check(hiz == 0 && drv_en == 1, "R1 hiz/drv_en", {hiz, drv_en}, 1);
    check(sticky_err == 0 && evt_fault == 0, "R1 sticky/evt", {sticky_err, evt_fault}, 0);
  endtask

  task automatic t_pin(input bit mask);
    cfg_evt_mask = mask;
    evt_cnt = 0;
    pin_dis = 1'b1;
    step(5);
    check(hiz == 1 && drv_en == 0, "R2 pin high", {hiz, drv_en}, 2);
    check(evt_cnt == (mask ? 0 : 1), "R7 pin event", evt_cnt, mask ? 0 : 1);
    check(evt_cnt <= 1, "R9 single pulse", evt_cnt, 1);
    pin_dis = 1'b0;
    step(4);
    check(hiz == 0 && drv_en == 1, "R2 pin low", {hiz, drv_en}, 1);
    check(sticky_err == 1, "R8 sticky held", sticky_err, 1);
    sticky_clr = 1'b1; step(1); sticky_clr = 1'b0; step(1);
    check(sticky_err == 0, "R8 sticky cleared", sticky_err, 0);
    cfg_evt_mask = 1'b0;
  endtask

  task automatic t_monitor();
    cfg_evt_mask = 1'b1;
    evt_cnt = 0;
    mon_err = 1'b1; step(1); mon_err = 1'b0;
    check(hiz == 1 && evt_fault == 1, "R6 monitor event", {hiz, evt_fault}, 3);
    step(4);
    check(hiz == 1, "R3 latch holds", hiz, 1);
    check(evt_cnt == 1, "R6 event count", evt_cnt, 1);
    pin_dis = 1'b1; step(4);
    check(evt_cnt == 1, "R9 no event while hiz", evt_cnt, 1);
    pin_dis = 1'b0; step(5);
    check(hiz == 0, "R5 pin fall clears latch", hiz, 0);
    sticky_clr = 1'b1; step(1); sticky_clr = 1'b0;
    cfg_evt_mask = 1'b0;
  endtask

  task automatic t_inhibit();
    cfg_mon_inhibit = 1'b1;
    evt_cnt = 0;
    mon_err = 1'b1; step(2); mon_err = 1'b0;
    step(3);
    check(hiz == 0 && drv_en == 1, "R4 inhibited hiz", hiz, 0);
    check(evt_cnt == 0 && sticky_err == 0, "R4 no event/sticky", evt_cnt, 0);
    cfg_mon_inhibit = 1'b0;
  endtask

  task automatic t_sticky_conflict();
    pin_dis = 1'b1; step(4);
    sticky_clr = 1'b1; step(2); sticky_clr = 1'b0;
    check(sticky_err == 1, "R8 set beats clear", sticky_err, 1);
    pin_dis = 1'b0; step(4);
    check(sticky_err == 1, "R8 sticky after release", sticky_err, 1);
    sticky_clr = 1'b1; step(1); sticky_clr = 1'b0; step(1);
    check(sticky_err == 0, "R8 clear when idle", sticky_err, 0);
  endtask

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_pin(1'b0);
    t_pin(1'b1);
    t_monitor();
    t_inhibit();
    t_sticky_conflict();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule